// File: doc/BRIEF.md
# Asynchronous SRAM sequencing controller

This block sits between a clocked request port and an asynchronous static RAM of 32,768 bytes. Each request is a single word, either a read or a write, and moves across a valid/ready handshake. The controller turns it into a timed pattern on the memory's active-low chip-select, write and output strobes, its 15-bit address and its 8-bit data bus. The data bus is split into an outgoing value, an incoming value and a driver enable. Read data comes back on a registered output with a one-cycle valid pulse. The port takes no new request until the current sequence has finished.

Each timing interval is a parameter in clock cycles, with a minimum of 1: the read access wait, the write-strobe pulse, the data setup before the strobe rises, the address setup before the strobe falls, and the bus turnaround after a read. One down-counter measures every interval. Every write keeps chip select low for its whole length and ends when the write strobe rises. Output enable stays high during writes, so the memory never drives the bus while the controller does.

The state machine has six states. ST_IDLE deselects the memory and offers ready. ST_TURN is the turnaround gap that a write gets when the previous access was a read. ST_WSETUP selects the chip with the write strobe high. ST_WLOW holds the write strobe low and drives data. ST_WHOLD raises the write strobe while the data is still driven. ST_RACC selects the chip with output enable low.

The transitions are:
- ST_IDLE to ST_RACC on an accepted read.
- ST_IDLE to ST_TURN on an accepted write when the last access was a read.
- ST_IDLE to ST_WSETUP on any other accepted write.
- ST_TURN to ST_WSETUP when its count expires.
- ST_WSETUP to ST_WLOW when its count expires.
- ST_WLOW to ST_WHOLD when its count expires.
- ST_WHOLD to ST_IDLE after one cycle.
- ST_RACC to ST_IDLE when its count expires, sampling the bus as it leaves.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever req_ready is high, sram_ce_n, sram_we_n and sram_oe_n are all 1 and sram_dq_oe is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from the cycle after acceptance until the sequence returns to idle. A req_valid presented during that time has no effect on the memory.
- R3: During a write, sram_we_n is 0 for exactly max(WPULSE_CYC, DSETUP_CYC) consecutive cycles. sram_we_n is 0 only while sram_ce_n is 0 and sram_oe_n is 1. Chip select rises only after the write strobe is already high, so the write strobe is what ends each write.
- R4: sram_dq_oe is 1 in every cycle with sram_we_n at 0 and in the cycle in which sram_we_n rises. sram_dq_out holds the accepted write data without change across that window.
- R5: A read holds sram_ce_n and sram_oe_n at 0 and sram_we_n at 1 for exactly ACC_CYC cycles. rsp_valid is a single-cycle pulse ACC_CYC+1 cycles after the accepting edge. rsp_rdata then carries the sram_dq_in value from the last cycle of that access.
- R6: sram_dq_oe is never 1 while sram_oe_n is 0.
- R7: A write whose previous access was a read first enters TURN_CYC turnaround cycles with the chip deselected. Its driver turns on only after output enable has been high for at least one cycle. Measured from acceptance, such a write returns to idle TURN_CYC cycles later than other writes.
- R8: Before the write strobe falls, chip select is low with both other strobes high for exactly ASETUP_CYC cycles.
- R9: sram_addr does not change while sram_ce_n is 0. A write becomes idle again ASETUP_CYC + max(WPULSE_CYC, DSETUP_CYC) + 2 cycles after acceptance (plus TURN_CYC under R7), and the data it writes reads back at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DATA_W | Data the controller drives |
| sram_dq_in | input | DATA_W | Data from the memory pins |
| sram_dq_oe | output | 1 | Controller data driver enable |

## Verification
The assertions check these properties on every cycle:
- the strobe combinations (R3 and R6);
- the exact lengths of the setup, write-low and read-access windows;
- address stability while the chip is selected (R9);
- a stable driven value across the write end (R4);
- a live driver only after output enable was already high (R7).

Some behaviour only the bench's scenarios can show. These are the latencies that depend on whether the previous access was a read, and the sampling of read data at the correct cycle. The bench's memory model shows the right byte only once the access window is full, so sampling one cycle early returns wrong data. The last such behaviour is that a request held up during a busy sequence leaves memory contents unchanged.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WLOW,
        ST_WHOLD,
        ST_RACC
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int ACC_CYC    = 3,
    parameter int WLOW_CYC   = 3,
    parameter int ASETUP_CYC = 1,
    parameter int TURN_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             take_req,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_load_val,
    output logic             rd_sample,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    seq_state_t state_q, state_d;
    logic       last_rd_q;

    // state register and read-history flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RACC && tmr_expired) begin
                last_rd_q <= 1'b1;
            end else if (state_q == ST_WHOLD) begin
                last_rd_q <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_d = ST_RACC;
                    end else if (last_rd_q) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_WSETUP;
                    end
                end
            end
            ST_TURN:   if (tmr_expired) state_d = ST_WSETUP;
            ST_WSETUP: if (tmr_expired) state_d = ST_WLOW;
            ST_WLOW:   if (tmr_expired) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            ST_RACC:   if (tmr_expired) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // timer reload on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_TURN:   tmr_load_val = CNT_W'(TURN_CYC - 1);
            ST_WSETUP: tmr_load_val = CNT_W'(ASETUP_CYC - 1);
            ST_WLOW:   tmr_load_val = CNT_W'(WLOW_CYC - 1);
            ST_RACC:   tmr_load_val = CNT_W'(ACC_CYC - 1);
            default:   tmr_load_val = '0;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rd_sample = 1'b0;
        ce_n      = 1'b1;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_TURN:   ;
            ST_WSETUP: ce_n = 1'b0;
            ST_WLOW: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_RACC: begin
                ce_n      = 1'b0;
                oe_n      = 1'b0;
                rd_sample = tmr_expired;
            end
            default: ;
        endcase
        take_req = req_ready && req_valid;
    end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_sample,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            dq_out    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_sample;
            if (take_req) begin
                addr   <= req_addr;
                dq_out <= req_wdata;
            end
            if (rd_sample) begin
                rsp_rdata <= dq_in;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int ACC_CYC    = 3,
    parameter int WPULSE_CYC = 2,
    parameter int DSETUP_CYC = 3,
    parameter int ASETUP_CYC = 1,
    parameter int TURN_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);

    localparam int WLOW_CYC = max2(WPULSE_CYC, DSETUP_CYC);
    localparam int MAX_CYC  = max2(max2(ACC_CYC, WLOW_CYC), max2(ASETUP_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             take_req;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_load_val;
    logic             tmr_expired;
    logic             rd_sample;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .expired  (tmr_expired)
    );

    asram_fsm #(
        .CNT_W      (CNT_W),
        .ACC_CYC    (ACC_CYC),
        .WLOW_CYC   (WLOW_CYC),
        .ASETUP_CYC (ASETUP_CYC),
        .TURN_CYC   (TURN_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .tmr_expired  (tmr_expired),
        .req_ready    (req_ready),
        .take_req     (take_req),
        .tmr_load     (tmr_load),
        .tmr_load_val (tmr_load_val),
        .rd_sample    (rd_sample),
        .ce_n         (sram_ce_n),
        .we_n         (sram_we_n),
        .oe_n         (sram_oe_n),
        .dq_oe        (sram_dq_oe)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (take_req),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_sample (rd_sample),
        .dq_in     (sram_dq_in),
        .addr      (sram_addr),
        .dq_out    (sram_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int ACC_CYC    = 3,
    parameter int WLOW_CYC   = 3,
    parameter int ASETUP_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);

    logic [15:0] wlow_run;
    logic [15:0] racc_run;
    logic [15:0] setup_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlow_run  <= '0;
            racc_run  <= '0;
            setup_run <= '0;
        end else begin
            wlow_run  <= !sram_we_n ? wlow_run + 1'b1 : '0;
            racc_run  <= !sram_oe_n ? racc_run + 1'b1 : '0;
            setup_run <= (!sram_ce_n && sram_we_n && sram_oe_n) ? setup_run + 1'b1 : '0;
        end
    end

    // R1
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R3
    we_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    // R3
    we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (wlow_run == 16'(WLOW_CYC)));

    // R3
    ce_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_ce_n) |-> $past(sram_we_n));

    // R4
    data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || $rose(sram_we_n)) |-> (sram_dq_oe && $stable(sram_dq_out)));

    // R5
    rd_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    // R5
    rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (racc_run == 16'(ACC_CYC)));

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> $past(sram_oe_n));

    // R8
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (setup_run == 16'(ASETUP_CYC)));

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ACC_CYC    (ACC_CYC),
    .WLOW_CYC   (WLOW_CYC),
    .ASETUP_CYC (ASETUP_CYC)
) u_chk (.*);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam int ACC = 3;
    localparam int WP = 2;
    localparam int DS = 3;
    localparam int AS = 1;
    localparam int TT = 2;
    localparam int WL = (WP > DS) ? WP : DS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = '0;

    int vectors = 0;
    int errors = 0;
    bit done = 0;
    bit contention = 0;
    bit last_rd = 0;

    logic [7:0] model_mem [int unsigned];
    logic [7:0] shadow    [int unsigned];
    logic       we_prev = 1'b1;
    int         acc_cnt = 0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .WPULSE_CYC(WP),
        .DSETUP_CYC(DS), .ASETUP_CYC(AS), .TURN_CYC(TT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
    );

    function automatic logic [7:0] mem_val(input int unsigned a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_val(input int unsigned a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    function automatic int exp_wr_lat(input bit after_read);
        return (after_read ? TT : 0) + AS + WL + 2;
    endfunction

    // memory model: byte stored on the rising write strobe, read data valid after ACC cycles
    always @(negedge clk) begin
        logic rd_act;
        rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
        if (sram_dq_oe && rd_act) contention = 1;
        if (we_prev == 1'b0 && sram_we_n && !sram_ce_n && sram_dq_oe)
            model_mem[int'(sram_addr)] = sram_dq_out;
        we_prev = sram_we_n;
        acc_cnt = rd_act ? acc_cnt + 1 : 0;
        sram_dq_in = (rd_act && acc_cnt >= ACC) ? mem_val(int'(sram_addr))
                                                : ~mem_val(int'(sram_addr));
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic check_idle(input string req);
        check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, req,
              {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 5'b11101);
    endtask

    // issue one request; junk: hold a different write on the port while busy
    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit junk);
        int lat;
        bit busy_ok;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            req_write = 1'b1; req_addr = a ^ 15'h0001; req_wdata = 8'hEE;
        end else begin
            req_valid = 1'b0;
        end
        lat = 1;
        busy_ok = 1;
        contention = 0;
        if (!wr) begin
            while (!rsp_valid && lat < 100) begin
                if (req_ready) busy_ok = 0;
                @(negedge clk); lat++;
            end
            req_valid = 1'b0;
            // R5
            check(lat == ACC + 1, "R5 read latency", lat, ACC + 1);
            check(rsp_rdata == exp_val(int'(a)), "R5 read data", rsp_rdata, exp_val(int'(a)));
            last_rd = 1;
        end else begin
            while (!req_ready && lat < 100) begin
                @(negedge clk); lat++;
            end
            req_valid = 1'b0;
            // R7 and R9
            check(lat == exp_wr_lat(last_rd), last_rd ? "R7 write after read latency"
                  : "R9 write latency", lat, exp_wr_lat(last_rd));
            shadow[int'(a)] = d;
            last_rd = 0;
        end
        // R2
        check(busy_ok, "R2 ready low while busy", busy_ok, 1);
        // R6
        check(!contention, "R6 bus contention", contention, 0);
        // R1
        check_idle("R1 idle after sequence");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_idle("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");

        // directed corners: unwritten read, lowest and highest address
        do_req(1'b0, 15'h0000, 8'h00, 0);
        do_req(1'b1, 15'h0000, 8'h3C, 0);
        do_req(1'b1, 15'h7FFF, 8'hC3, 0);
        do_req(1'b0, 15'h7FFF, 8'h00, 0);
        do_req(1'b0, 15'h0000, 8'h00, 0);
        // read followed by write: turnaround path (R7)
        do_req(1'b1, 15'h0000, 8'hA1, 0);
        do_req(1'b0, 15'h0000, 8'h00, 0);
        // R2: request held during a busy write must not reach memory
        do_req(1'b1, 15'h0010, 8'h55, 1);
        do_req(1'b0, 15'h0011, 8'h00, 0);
        do_req(1'b0, 15'h0010, 8'h00, 0);
        // R2: request held during a busy read
        do_req(1'b0, 15'h0020, 8'h00, 1);
        do_req(1'b0, 15'h0021, 8'h00, 0);

        // random mix over a small window so reads hit written bytes
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = AW'(15'h1200 + ($urandom % 24));
            do_req(1'(($urandom % 2)), a, 8'($urandom), 0);
        end
        // final sweep: every byte of the window reads back (R9)
        for (int j = 0; j < 24; j++) begin
            do_req(1'b0, AW'(15'h1200 + j), 8'h00, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule